// File: doc/BRIEF.md
# Frame Header Byte Stripper

This block is a byte-stream stage placed after frame delineation in a packet decapsulation path. It accepts one byte per cycle under a ready/valid handshake, with start-of-frame and end-of-frame markers. It deletes selected runs of bytes from each frame before passing the frame on under the same handshake.

Three chained header rules can act on the front of a frame:
- The first deletes a 4-byte run.
- The second deletes the next 4-byte run.
- The third lets 12 bytes through and then deletes 4.

A trailing check sequence of 2 or 4 bytes can also be removed. Doing so means the newest bytes of the frame are held back until the end marker shows which bytes form the tail.

Configuration is taken from static inputs on the start-of-frame beat. A frame too short to cover its own header and trailer is discarded whole and flagged.

Top module: `frame_hdr_stripper`

## Requirements
- R1: With `rm1_en_i` set, frame bytes 0 to 3 (counted from the start-of-frame beat, index 0) produce no output beat.
- R2: With `rm2_en_i` set, the 4 bytes after the rule-1 region are deleted. These are bytes 4 to 7 when `rm1_en_i` is set, and bytes 0 to 3 when it is clear.
- R3: With `rm3_en_i` set, 12 bytes pass and the following 4 are deleted. The 12-byte window begins where the enabled rules 1/2 end, or at byte 0 when neither is enabled.
- R4: With `trl_en_i` set, the last 2 bytes (`trl_long_i`=0) or the last 4 bytes (`trl_long_i`=1) of the frame are removed, and `out_eof_o` is carried on the last surviving byte.
- R5: With `trl_en_i` clear, no trailing byte is removed, whatever the value of `trl_long_i`.
- R6: All five control inputs are sampled on the accepted start-of-frame beat. Changing them on later beats of the same frame has no effect on that frame.
- R7: `out_sof_o` is asserted on the first byte of a frame that survives removal, and on no other beat.
- R8: A frame is dropped with no output beat at all when its length is below the total header length plus the trailer length, or when no byte would survive. In that case `short_err_o` is high for exactly the one cycle after the end-of-frame beat is accepted.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o`, `out_sof_o` and `out_eof_o` hold steady. No byte is lost or duplicated under any pattern of stalls on either side.
- R10: After reset, `out_valid_o` and `short_err_o` are low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Stage can accept an input beat |
| in_data_i | input | DATA_W | Input byte |
| in_sof_i | input | 1 | Input beat is the first of a frame |
| in_eof_i | input | 1 | Input beat is the last of a frame |
| rm1_en_i | input | 1 | Delete the first 4-byte header run |
| rm2_en_i | input | 1 | Delete the 4-byte run after the rule-1 region |
| rm3_en_i | input | 1 | Pass 12 bytes, then delete 4 |
| trl_en_i | input | 1 | Remove the trailing check sequence |
| trl_long_i | input | 1 | Trailer is 4 bytes when set, 2 bytes when clear |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream accepts the output beat |
| out_data_o | output | DATA_W | Output byte |
| out_sof_o | output | 1 | Output beat is the first surviving byte |
| out_eof_o | output | 1 | Output beat is the last surviving byte |
| short_err_o | output | 1 | One-cycle pulse for a dropped short frame |

## Verification
The bench builds the block with its defaults: `DATA_W` of 8 and a hold buffer of 16 entries. Sixteen entries is exactly the worst case: twelve rule-3 pass-through bytes held until the frame proves long enough, plus a 4-byte trailer. Random stalls on both sides therefore drive the buffer full and exercise input backpressure. Frames sized just below, at and just above the header-plus-trailer length reach the drop and empty-output boundaries. A control change on a non-first beat shows whether the per-frame sampling holds.

// File: rtl/hdr_strip_pkg.sv
package hdr_strip_pkg;
  localparam int unsigned RM_LEN    = 4;
  localparam int unsigned SKIP_LEN  = 12;
  localparam int unsigned TRL_SHORT = 2;
  localparam int unsigned TRL_LONG  = 4;
  localparam int unsigned HDR_MAX   = 2 * RM_LEN + SKIP_LEN + RM_LEN;
  localparam int unsigned NEED_MAX  = HDR_MAX + TRL_LONG;
  localparam int unsigned IDX_W     = $clog2(NEED_MAX + 2);

  typedef struct packed {
    logic rm1;
    logic rm2;
    logic rm3;
    logic trl_en;
    logic trl_long;
  } strip_cfg_t;

  function automatic logic [2:0] trl_bytes(strip_cfg_t c);
    if (!c.trl_en) return 3'd0;
    return c.trl_long ? 3'(TRL_LONG) : 3'(TRL_SHORT);
  endfunction
endpackage

// File: rtl/hdr_strip_map.sv
module hdr_strip_map
  import hdr_strip_pkg::*;
(
  input  strip_cfg_t       cfg_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             drop_o,
  output logic [IDX_W:0]   need_o
);
  logic [IDX_W:0] idx_x, o1, o2, gap_lo, hdr_end;

  always_comb begin
    idx_x   = {1'b0, idx_i};
    o1      = cfg_i.rm1 ? (IDX_W+1)'(RM_LEN) : '0;
    o2      = o1 + (cfg_i.rm2 ? (IDX_W+1)'(RM_LEN) : '0);
    gap_lo  = o2 + (IDX_W+1)'(SKIP_LEN);
    hdr_end = cfg_i.rm3 ? gap_lo + (IDX_W+1)'(RM_LEN) : o2;
    drop_o  = (idx_x < o2) || (cfg_i.rm3 && idx_x >= gap_lo && idx_x < hdr_end);
    need_o  = hdr_end + (IDX_W+1)'(trl_bytes(cfg_i));
  end
endmodule

// File: rtl/hdr_strip_buf.sv
module hdr_strip_buf #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [W-1:0]     head_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem[wr_q] <= data_i;
  end

  assign cnt_o  = cnt_q;
  assign head_o = mem[rd_q];

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !clr_i |-> (cnt_q < CNT_W'(DEPTH)) || pop_i);
  p_no_underflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !clr_i |-> cnt_q != '0);
endmodule

// File: rtl/frame_hdr_stripper.sv
module frame_hdr_stripper
  import hdr_strip_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BUF_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic              rm1_en_i,
  input  logic              rm2_en_i,
  input  logic              rm3_en_i,
  input  logic              trl_en_i,
  input  logic              trl_long_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_eof_o,
  output logic              short_err_o
);
  localparam int unsigned CNT_W = $clog2(BUF_DEPTH + 1);

  strip_cfg_t       cfg_q, cfg_in, cfg_cur;
  logic [IDX_W-1:0] idx_q, idx_cur;
  logic [IDX_W:0]   need, len;
  logic             drop_byte;
  logic [CNT_W-1:0] fifo_cnt, trl_q_c, trl_cur_c;
  logic [CNT_W:0]   cnt_after;
  logic             armed_q, closing_q, sof_pend_q, err_q;
  logic             in_fire, out_fire, push, eof_acc, drop_frame, close_done;
  logic             mid_rel, cls_rel;

  assign cfg_in  = '{rm1: rm1_en_i, rm2: rm2_en_i, rm3: rm3_en_i,
                     trl_en: trl_en_i, trl_long: trl_long_i};
  assign cfg_cur = in_sof_i ? cfg_in : cfg_q;
  assign idx_cur = in_sof_i ? '0 : idx_q;
  assign len     = {1'b0, idx_cur} + (IDX_W+1)'(1);

  hdr_strip_map u_map (
    .cfg_i  (cfg_cur),
    .idx_i  (idx_cur),
    .drop_o (drop_byte),
    .need_o (need)
  );

  assign trl_q_c   = CNT_W'(trl_bytes(cfg_q));
  assign trl_cur_c = CNT_W'(trl_bytes(cfg_cur));

  assign in_ready_o = !closing_q && (fifo_cnt < CNT_W'(BUF_DEPTH));
  assign in_fire    = in_valid_i && in_ready_o;
  assign push       = in_fire && !drop_byte;
  assign eof_acc    = in_fire && in_eof_i;

  // Mid-frame: keep trailer plus one byte back so the end marker has a home.
  assign mid_rel     = armed_q && !closing_q && (fifo_cnt > trl_q_c + CNT_W'(1));
  assign cls_rel     = closing_q && (fifo_cnt > trl_q_c);
  assign out_valid_o = mid_rel || cls_rel;
  assign out_fire    = out_valid_o && out_ready_i;
  assign out_eof_o   = closing_q && (fifo_cnt == trl_q_c + CNT_W'(1));
  assign out_sof_o   = sof_pend_q;

  assign cnt_after  = {1'b0, fifo_cnt} + (CNT_W+1)'(push) - (CNT_W+1)'(out_fire);
  assign drop_frame = eof_acc && ((len < need) || (cnt_after <= {1'b0, trl_cur_c}));
  assign close_done = out_fire && out_eof_o;

  hdr_strip_buf #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .data_i (in_data_i),
    .pop_i  (out_fire),
    .clr_i  (drop_frame || close_done),
    .cnt_o  (fifo_cnt),
    .head_o (out_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      idx_q      <= '0;
      armed_q    <= 1'b0;
      closing_q  <= 1'b0;
      sof_pend_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      err_q <= drop_frame;
      if (in_fire) begin
        idx_q   <= (idx_cur == '1) ? idx_cur : idx_cur + IDX_W'(1);
        armed_q <= !in_eof_i && (len >= need);
        if (in_sof_i) cfg_q <= cfg_in;
      end
      if (eof_acc && !drop_frame) closing_q <= 1'b1;
      else if (close_done)        closing_q <= 1'b0;
      if (drop_frame)                 sof_pend_q <= 1'b0;
      else if (in_fire && in_sof_i)   sof_pend_q <= 1'b1;
      else if (out_fire)              sof_pend_q <= 1'b0;
    end
  end

  assign short_err_o = err_q;

  // Assertion-only tracking of an open output frame.
  logic open_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       open_q <= 1'b0;
    else if (out_fire) open_q <= !out_eof_o;
  end

  p_hold_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_sof_o) && $stable(out_eof_o));
  p_sof_opens_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire |-> (out_sof_o == !open_q));
  p_drop_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_err_o |-> !out_valid_o);
  p_err_after_eof_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_err_o |-> $past(in_valid_i && in_ready_o && in_eof_i));
endmodule

// File: tb/frame_hdr_stripper_tb.sv
`timescale 1ns/1ps
module frame_hdr_stripper_tb;
  localparam int MAXB = 1024;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, out_ready = 0;
  logic [7:0] in_data = '0;
  logic rm1 = 0, rm2 = 0, rm3 = 0, ten = 0, tlong = 0;
  logic in_ready, out_valid, out_sof, out_eof, short_err;
  logic [7:0] out_data;

  always #2 clk = ~clk;

  frame_hdr_stripper u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_sof_i(in_sof), .in_eof_i(in_eof),
    .rm1_en_i(rm1), .rm2_en_i(rm2), .rm3_en_i(rm3), .trl_en_i(ten), .trl_long_i(tlong),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_sof_o(out_sof), .out_eof_o(out_eof), .short_err_o(short_err));

  int n_chk = 0, n_fail = 0;
  logic [7:0] s_data [MAXB];
  logic       s_sof [MAXB], s_eof [MAXB];
  logic [4:0] s_cfg [MAXB];
  logic [9:0] e_beat [MAXB];
  logic [9:0] g_beat [MAXB];
  int n_stim = 0, n_exp = 0, n_got = 0, exp_err = 0, got_err = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // cfg bits: {rm1, rm2, rm3, trl_en, trl_long}
  task automatic add_frame(input int len, input logic [4:0] cfg, input logic [4:0] later, input logic [7:0] base);
    int o1, o2, gl, he, trl, need, nk;
    logic [7:0] kept [64];
    o1 = cfg[4] ? 4 : 0;
    o2 = o1 + (cfg[3] ? 4 : 0);
    gl = o2 + 12;
    he = cfg[2] ? gl + 4 : o2;
    trl = cfg[1] ? (cfg[0] ? 4 : 2) : 0;
    need = he + trl;
    nk = 0;
    for (int i = 0; i < len; i++) begin
      s_data[n_stim] = base + 8'(i);
      s_sof[n_stim]  = (i == 0);
      s_eof[n_stim]  = (i == len - 1);
      s_cfg[n_stim]  = (i == 0) ? cfg : later;
      n_stim++;
      if (!((i < o2) || (cfg[2] && i >= gl && i < he))) begin
        kept[nk] = base + 8'(i);
        nk++;
      end
    end
    if (len < need || nk <= trl) exp_err++;
    else
      for (int k = 0; k < nk - trl; k++) begin
        e_beat[n_exp] = {k == 0, k == nk - trl - 1, kept[k]};
        n_exp++;
      end
  endtask

  task automatic run_traffic(input string req, input bit rnd_out, input bit rnd_in);
    int sp = 0, idle = 0, guard = 0;
    bit stall = 0;
    logic [9:0] held = '0;
    n_got = 0; got_err = 0;
    while (idle < 40 && guard < 20000) begin
      @(negedge clk);
      guard++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid  = (sp < n_stim) && (!rnd_in || lfsr[0] || lfsr[3]);
      out_ready = !rnd_out || lfsr[5];
      if (sp < n_stim) begin
        in_data = s_data[sp]; in_sof = s_sof[sp]; in_eof = s_eof[sp];
        {rm1, rm2, rm3, ten, tlong} = s_cfg[sp];
      end
      #1;
      if (stall)
        chk(out_valid && {out_sof, out_eof, out_data} == held, "R9", "held beat",
            int'({out_valid, out_sof, out_eof, out_data}), int'({1'b1, held}));
      stall = out_valid && !out_ready;
      held  = {out_sof, out_eof, out_data};
      if (short_err) got_err++;
      if (out_valid && out_ready && n_got < MAXB) begin
        g_beat[n_got] = {out_sof, out_eof, out_data};
        n_got++;
      end
      if (in_valid && in_ready) sp++;
      idle = (sp == n_stim && !out_valid) ? idle + 1 : 0;
    end
    @(negedge clk);
    in_valid = 0; out_ready = 0;
    chk(sp == n_stim, req, "inputs consumed", sp, n_stim);
    chk(n_got == n_exp, req, "beat count", n_got, n_exp);
    for (int k = 0; k < n_exp && k < n_got; k++)
      chk(g_beat[k] == e_beat[k], req, $sformatf("beat %0d {sof,eof,data}", k),
          int'(g_beat[k]), int'(e_beat[k]));
    chk(got_err == exp_err, req, "short_err pulses", got_err, exp_err);
    n_stim = 0; n_exp = 0; exp_err = 0;
  endtask

  task automatic t_reset_r10();
    #1;
    chk(!out_valid, "R10", "out_valid after reset", out_valid, 0);
    chk(!short_err, "R10", "short_err after reset", short_err, 0);
    chk(in_ready, "R10", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_rule1_r1();
    add_frame(8, 5'b10000, 5'b10000, 8'h10);
    add_frame(10, 5'b10000, 5'b10000, 8'h30);
    add_frame(5, 5'b00000, 5'b00000, 8'h50);
    run_traffic("R1", 0, 0);
  endtask

  task automatic t_rule2_r2();
    add_frame(12, 5'b11000, 5'b11000, 8'h20);
    add_frame(9, 5'b01000, 5'b01000, 8'h40);
    run_traffic("R2", 0, 0);
  endtask

  task automatic t_rule3_r3();
    add_frame(24, 5'b00100, 5'b00100, 8'h00);
    add_frame(25, 5'b10100, 5'b10100, 8'h40);
    add_frame(30, 5'b11100, 5'b11100, 8'h80);
    add_frame(16, 5'b00100, 5'b00100, 8'hC0);
    run_traffic("R3", 0, 0);
  endtask

  task automatic t_trailer_r4();
    add_frame(10, 5'b00010, 5'b00010, 8'h10);
    add_frame(10, 5'b00011, 5'b00011, 8'h30);
    add_frame(14, 5'b10011, 5'b10011, 8'h50);
    add_frame(24, 5'b00111, 5'b00111, 8'h70);
    run_traffic("R4", 0, 0);
  endtask

  task automatic t_no_trailer_r5();
    add_frame(6, 5'b00001, 5'b00001, 8'h60);
    add_frame(6, 5'b00000, 5'b00000, 8'h70);
    add_frame(1, 5'b00001, 5'b00001, 8'h80);
    run_traffic("R5", 0, 0);
  endtask

  task automatic t_cfg_hold_r6();
    add_frame(12, 5'b10000, 5'b11111, 8'h90);
    add_frame(26, 5'b00100, 5'b10011, 8'hA0);
    add_frame(8, 5'b00011, 5'b00000, 8'hC0);
    run_traffic("R6", 0, 0);
  endtask

  task automatic t_sof_move_r7();
    add_frame(20, 5'b11010, 5'b11010, 8'h05);
    add_frame(3, 5'b00000, 5'b00000, 8'h55);
    run_traffic("R7", 1, 1);
  endtask

  task automatic t_short_r8();
    add_frame(3, 5'b10000, 5'b10000, 8'h01);
    add_frame(5, 5'b10011, 5'b10011, 8'h11);
    add_frame(8, 5'b10011, 5'b10011, 8'h21);
    add_frame(19, 5'b00111, 5'b00111, 8'h31);
    add_frame(9, 5'b10011, 5'b10011, 8'h41);
    add_frame(1, 5'b00010, 5'b00010, 8'h51);
    add_frame(2, 5'b00000, 5'b00000, 8'h61);
    run_traffic("R8", 0, 0);
  endtask

  task automatic t_backpressure_r9();
    add_frame(40, 5'b00111, 5'b00111, 8'h00);
    add_frame(30, 5'b11011, 5'b11011, 8'h40);
    add_frame(4, 5'b10000, 5'b10000, 8'h80);
    add_frame(33, 5'b10110, 5'b10110, 8'h90);
    add_frame(1, 5'b00000, 5'b00000, 8'hF0);
    run_traffic("R9", 1, 1);
    add_frame(36, 5'b00101, 5'b00101, 8'h20);
    add_frame(22, 5'b01100, 5'b01100, 8'h60);
    run_traffic("R9", 1, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_r10();
    t_rule1_r1();
    t_rule2_r2();
    t_rule3_r3();
    t_trailer_r4();
    t_no_trailer_r5();
    t_cfg_hold_r6();
    t_sof_move_r7();
    t_short_r8();
    t_backpressure_r9();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule